// File: doc/BRIEF.md
# Configuration Capability List Walker

This engine searches the 256-byte configuration space of a device for a capability block. It first reads the header-type byte and reports the header format. It then reads the capability pointer held in the header and follows the chain of next pointers from block to block. The walk stops at the first block whose ID byte equals the requested ID. When type matching is enabled, that block's type byte must also equal the requested type.

Configuration space is reached through a dword-wide read port. The engine raises a request with a dword address and holds it until the storage answers with a one-cycle valid strobe. The response may take any number of cycles. A start pulse carries the requested ID, the requested type and a type-enable bit. The engine reports back through five outputs:
- the header format;
- a found flag and the byte offset of the matching block;
- the number of blocks read;
- an error flag.

An error is raised when a pointer lands inside the header. It is also raised when the walk runs past the number of blocks the space can hold, which is how a circular chain shows up.

Top module: `capListWalker`

## Requirements
- R1: After reset `busy`, `done`, `found`, `errFlag` and `rdReq` are low, and `foundOffset` and `blockCount` are zero.
- R2: The first read after a start goes to dword 3. `hdrType` then reports bits 22:16 of that dword, which are the low seven bits of the header-type byte at byte offset 0x0E.
- R3: The second read goes to dword 13. Bits 7:0 of that dword form the first block pointer. The pointer has its low two bits forced to zero, and the block is read at dword index pointer[7:2].
- R4: While `rdReq` is high and `rdValid` has not yet arrived, `rdReq` stays high and `rdAddr` does not change.
- R5: A block matches when its bits 7:0 equal `reqId`. When `useType` is 1, its bits 31:24 must also equal `reqType`; when `useType` is 0, the type byte is ignored. The first match ends the walk with `found`=1 and `foundOffset` set to the aligned byte offset of that block.
- R6: The next pointer of a non-matching block is taken from bits 15:8, with its low two bits cleared. An aligned pointer of zero ends the walk with `found`=0, `errFlag`=0 and `foundOffset`=0.
- R7: An aligned pointer from 0x04 to 0x3F sets `errFlag` and ends the walk, and no further read is issued.
- R8: After 48 blocks have been read without a match or a zero pointer, a further nonzero pointer sets `errFlag` and ends the walk. A chain of exactly 48 blocks that ends in a zero pointer is not an error.
- R9: `blockCount` equals the number of capability blocks read during the walk, including the matching block.
- R10: `busy` is high from the cycle after an accepted start until the cycle of the one-cycle `done` pulse. A start pulse while `busy` is high is ignored.
- R11: The results keep their values from the `done` pulse until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; accepted only when idle |
| reqId | input | 8 | Requested capability ID |
| reqType | input | 8 | Requested block type |
| useType | input | 1 | 1: the type byte must also match |
| rdReq | output | 1 | Read request to configuration storage |
| rdAddr | output | 6 | Dword index of the read |
| rdValid | input | 1 | Read response strobe |
| rdData | input | 32 | Read response data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Matching block located |
| foundOffset | output | 8 | Byte offset of the matching block |
| blockCount | output | 6 | Blocks read during the walk |
| errFlag | output | 1 | Pointer into header or visit limit exceeded |
| hdrType | output | 7 | Header format from the header-type byte |

## Verification
The bench builds the block with its default parameters: a 256-byte space, a 16-dword header and, from those, a 48-block visit limit. With these values a chain that fills every dword above the header can be built, so the exact-limit case is reachable. A circular chain also reaches the limit error, and a pointer aimed back into the header triggers the header error. Random chains with random read latency exercise the hold of the read address and the cases where the type byte does and does not matter.

// File: rtl/capWalkPkg.sv
package capWalkPkg;

  typedef enum logic [1:0] {
    SEL_HDR = 2'd0,
    SEL_CAP = 2'd1,
    SEL_BLK = 2'd2
  } addrSel_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HDR  = 3'd1,
    ST_CAP  = 3'd2,
    ST_CHK  = 3'd3,
    ST_BLK  = 3'd4,
    ST_FIN  = 3'd5
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     latchReq;
    logic     loadHdr;
    logic     loadFirst;
    logic     loadNext;
    logic     incCount;
    logic     setFound;
    logic     setErr;
    addrSel_e addrSel;
  } walkCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic ptrZero;
    logic ptrInHdr;
    logic atLimit;
    logic blockHit;
  } walkSts_t;

endpackage

// File: rtl/capWalkDatapath.sv
module capWalkDatapath
  import capWalkPkg::*;
#(
  parameter int CFG_BYTES   = 256,
  parameter int HDR_DWORDS  = 16,
  parameter int HDR_TYPE_DW = 3,
  parameter int CAP_PTR_DW  = 13,
  localparam int PTR_W      = $clog2(CFG_BYTES),
  localparam int DW_W       = PTR_W - 2,
  localparam int MAX_BLOCKS = CFG_BYTES / 4 - HDR_DWORDS,
  localparam int CNT_W      = $clog2(MAX_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  walkCtl_t         ctl,
  output walkSts_t         sts,
  input  logic [7:0]       reqId,
  input  logic [7:0]       reqType,
  input  logic             useType,
  input  logic [31:0]      rdData,
  output logic [DW_W-1:0]  rdAddr,
  output logic             found,
  output logic [PTR_W-1:0] foundOffset,
  output logic [CNT_W-1:0] blockCount,
  output logic             errFlag,
  output logic [6:0]       hdrType
);

  localparam logic [PTR_W-1:0] HDR_LIMIT = PTR_W'(HDR_DWORDS * 4);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(MAX_BLOCKS);
  localparam logic [DW_W-1:0]  HDR_DW    = DW_W'(HDR_TYPE_DW);
  localparam logic [DW_W-1:0]  CAP_DW    = DW_W'(CAP_PTR_DW);

  logic [7:0]       reqIdQ;
  logic [7:0]       reqTypeQ;
  logic             useTypeQ;
  logic [PTR_W-1:0] curPtr;
  logic [PTR_W-1:0] firstPtr;
  logic [PTR_W-1:0] nextPtr;

  // pointers are forced to dword alignment
  assign firstPtr = {rdData[PTR_W-1:2], 2'b00};
  assign nextPtr  = {rdData[8+PTR_W-1:10], 2'b00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqIdQ   <= '0;
      reqTypeQ <= '0;
      useTypeQ <= 1'b0;
    end else if (ctl.latchReq) begin
      reqIdQ   <= reqId;
      reqTypeQ <= reqType;
      useTypeQ <= useType;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPtr <= '0;
    end else if (ctl.latchReq) begin
      curPtr <= '0;
    end else if (ctl.loadFirst) begin
      curPtr <= firstPtr;
    end else if (ctl.loadNext) begin
      curPtr <= nextPtr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      found       <= 1'b0;
      foundOffset <= '0;
      blockCount  <= '0;
      errFlag     <= 1'b0;
      hdrType     <= '0;
    end else if (ctl.latchReq) begin
      found       <= 1'b0;
      foundOffset <= '0;
      blockCount  <= '0;
      errFlag     <= 1'b0;
    end else begin
      if (ctl.loadHdr)  hdrType <= rdData[22:16];
      if (ctl.incCount) blockCount <= blockCount + 1'b1;
      if (ctl.setFound) begin
        found       <= 1'b1;
        foundOffset <= curPtr;
      end
      if (ctl.setErr)   errFlag <= 1'b1;
    end
  end

  always_comb begin
    sts.ptrZero  = (curPtr == '0);
    sts.ptrInHdr = (curPtr < HDR_LIMIT);
    sts.atLimit  = (blockCount == CNT_MAX);
    sts.blockHit = (rdData[7:0] == reqIdQ) &&
                   (!useTypeQ || (rdData[31:24] == reqTypeQ));
  end

  always_comb begin
    unique case (ctl.addrSel)
      SEL_HDR: rdAddr = HDR_DW;
      SEL_CAP: rdAddr = CAP_DW;
      SEL_BLK: rdAddr = curPtr[PTR_W-1:2];
      default: rdAddr = HDR_DW;
    endcase
  end

endmodule

// File: rtl/capWalkCtrl.sv
module capWalkCtrl
  import capWalkPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     rdValid,
  input  walkSts_t sts,
  output walkCtl_t ctl,
  output logic     rdReq,
  output logic     busy,
  output logic     done
);

  walkState_e state;
  walkState_e nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    ctl         = '0;
    ctl.addrSel = SEL_HDR;
    rdReq       = 1'b0;
    busy        = (state != ST_IDLE);
    done        = (state == ST_FIN);
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.latchReq = 1'b1;
          nextState    = ST_HDR;
        end
      end
      ST_HDR: begin
        rdReq       = 1'b1;
        ctl.addrSel = SEL_HDR;
        if (rdValid) begin
          ctl.loadHdr = 1'b1;
          nextState   = ST_CAP;
        end
      end
      ST_CAP: begin
        rdReq       = 1'b1;
        ctl.addrSel = SEL_CAP;
        if (rdValid) begin
          ctl.loadFirst = 1'b1;
          nextState     = ST_CHK;
        end
      end
      ST_CHK: begin
        if (sts.ptrZero) begin
          nextState = ST_FIN;
        end else if (sts.ptrInHdr || sts.atLimit) begin
          ctl.setErr = 1'b1;
          nextState  = ST_FIN;
        end else begin
          nextState = ST_BLK;
        end
      end
      ST_BLK: begin
        rdReq       = 1'b1;
        ctl.addrSel = SEL_BLK;
        if (rdValid) begin
          ctl.incCount = 1'b1;
          if (sts.blockHit) begin
            ctl.setFound = 1'b1;
            nextState    = ST_FIN;
          end else begin
            ctl.loadNext = 1'b1;
            nextState    = ST_CHK;
          end
        end
      end
      ST_FIN: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/capListWalker.sv
module capListWalker
  import capWalkPkg::*;
#(
  parameter int CFG_BYTES   = 256,
  parameter int HDR_DWORDS  = 16,
  parameter int HDR_TYPE_DW = 3,
  parameter int CAP_PTR_DW  = 13,
  localparam int PTR_W      = $clog2(CFG_BYTES),
  localparam int DW_W       = PTR_W - 2,
  localparam int MAX_BLOCKS = CFG_BYTES / 4 - HDR_DWORDS,
  localparam int CNT_W      = $clog2(MAX_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       reqId,
  input  logic [7:0]       reqType,
  input  logic             useType,
  output logic             rdReq,
  output logic [DW_W-1:0]  rdAddr,
  input  logic             rdValid,
  input  logic [31:0]      rdData,
  output logic             busy,
  output logic             done,
  output logic             found,
  output logic [PTR_W-1:0] foundOffset,
  output logic [CNT_W-1:0] blockCount,
  output logic             errFlag,
  output logic [6:0]       hdrType
);

  walkCtl_t ctl;
  walkSts_t sts;

  capWalkCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .rdValid (rdValid),
    .sts     (sts),
    .ctl     (ctl),
    .rdReq   (rdReq),
    .busy    (busy),
    .done    (done)
  );

  capWalkDatapath #(
    .CFG_BYTES   (CFG_BYTES),
    .HDR_DWORDS  (HDR_DWORDS),
    .HDR_TYPE_DW (HDR_TYPE_DW),
    .CAP_PTR_DW  (CAP_PTR_DW)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .sts         (sts),
    .reqId       (reqId),
    .reqType     (reqType),
    .useType     (useType),
    .rdData      (rdData),
    .rdAddr      (rdAddr),
    .found       (found),
    .foundOffset (foundOffset),
    .blockCount  (blockCount),
    .errFlag     (errFlag),
    .hdrType     (hdrType)
  );

endmodule

// File: rtl/capWalkChecker.sv
module capWalkChecker #(
  parameter int CFG_BYTES   = 256,
  parameter int HDR_DWORDS  = 16,
  parameter int HDR_TYPE_DW = 3,
  parameter int CAP_PTR_DW  = 13,
  localparam int PTR_W      = $clog2(CFG_BYTES),
  localparam int DW_W       = PTR_W - 2,
  localparam int MAX_BLOCKS = CFG_BYTES / 4 - HDR_DWORDS,
  localparam int CNT_W      = $clog2(MAX_BLOCKS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             rdReq,
  input logic [DW_W-1:0]  rdAddr,
  input logic             rdValid,
  input logic             busy,
  input logic             done,
  input logic             found,
  input logic [PTR_W-1:0] foundOffset,
  input logic [CNT_W-1:0] blockCount,
  input logic             errFlag
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rdReq);

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid) |=> (rdReq && $stable(rdAddr)));

  p_one_result_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(found && errFlag));

  p_no_header_fetch_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> (rdAddr == DW_W'(HDR_TYPE_DW) || rdAddr == DW_W'(CAP_PTR_DW) ||
               rdAddr >= DW_W'(HDR_DWORDS)));

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    blockCount <= CNT_W'(MAX_BLOCKS));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  p_busy_end_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  p_results_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(found) && $stable(foundOffset) &&
                           $stable(errFlag) && $stable(blockCount)));

endmodule

bind capListWalker capWalkChecker #(
  .CFG_BYTES   (CFG_BYTES),
  .HDR_DWORDS  (HDR_DWORDS),
  .HDR_TYPE_DW (HDR_TYPE_DW),
  .CAP_PTR_DW  (CAP_PTR_DW)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .rdReq       (rdReq),
  .rdAddr      (rdAddr),
  .rdValid     (rdValid),
  .busy        (busy),
  .done        (done),
  .found       (found),
  .foundOffset (foundOffset),
  .blockCount  (blockCount),
  .errFlag     (errFlag)
);

// File: tb/tb_capListWalker.sv
module tb_capListWalker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  reqId = '0;
  logic [7:0]  reqType = '0;
  logic        useType = 1'b0;
  logic        rdReq;
  logic [5:0]  rdAddr;
  logic        rdValid = 1'b0;
  logic [31:0] rdData = '0;
  logic        busy, done, found, errFlag;
  logic [7:0]  foundOffset;
  logic [5:0]  blockCount;
  logic [6:0]  hdrType;

  int checks = 0;
  int errors = 0;

  logic [31:0] cfgMem [64];
  logic [5:0]  addrLog [64];
  int          logN = 0;

  // expected results from the bench model
  logic       expFound, expErr;
  logic [7:0] expOff;
  int         expCnt;

  always #5 clk = ~clk;

  capListWalker dut (
    .clk(clk), .rstN(rstN), .start(start), .reqId(reqId), .reqType(reqType),
    .useType(useType), .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid),
    .rdData(rdData), .busy(busy), .done(done), .found(found),
    .foundOffset(foundOffset), .blockCount(blockCount), .errFlag(errFlag),
    .hdrType(hdrType)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // storage responder with random latency; also watches address hold (R4)
  logic [5:0] heldAddr = '0;
  int         waitCnt = 0;
  logic       waiting = 1'b0;
  always @(negedge clk) begin
    if (rdValid) begin
      rdValid = 1'b0;
      waiting = 1'b0;
    end else if (rdReq) begin
      if (!waiting) begin
        waiting  = 1'b1;
        heldAddr = rdAddr;
        waitCnt  = $urandom % 4;
      end else if (rdAddr !== heldAddr) begin
        chk("R4 address hold", {26'd0, rdAddr}, {26'd0, heldAddr});
      end
      if (waitCnt == 0) begin
        rdValid = 1'b1;
        rdData  = cfgMem[rdAddr];
        if (logN < 64) addrLog[logN] = rdAddr;
        logN++;
      end else begin
        waitCnt--;
      end
    end
  end

  function automatic void model(input logic [7:0] id, input logic [7:0] ty, input logic ut);
    logic [7:0] p;
    logic [31:0] d;
    expFound = 1'b0; expErr = 1'b0; expOff = '0; expCnt = 0;
    p = cfgMem[13][7:0] & 8'hFC;
    forever begin
      if (p == 8'h00) return;
      if (p < 8'h40 || expCnt == 48) begin expErr = 1'b1; return; end
      d = cfgMem[p[7:2]];
      expCnt++;
      if (d[7:0] == id && (!ut || d[31:24] == ty)) begin
        expFound = 1'b1; expOff = p; return;
      end
      p = d[15:8] & 8'hFC;
    end
  endfunction

  task automatic waitDone(output logic ok);
    int guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    ok = done;
    if (!ok) chk("R10 done timeout", 32'd0, 32'd1);
  endtask

  task automatic runWalk(input logic [7:0] id, input logic [7:0] ty, input logic ut);
    logic ok;
    model(id, ty, ut);
    @(negedge clk);
    reqId = id; reqType = ty; useType = ut; start = 1'b1;
    logN = 0;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", {31'd0, busy}, 32'd1);
    chk("R2 first read address", {26'd0, rdAddr}, 32'd3);
    waitDone(ok);
    if (ok) begin
      chk("R5 found", {31'd0, found}, {31'd0, expFound});
      chk("R5 R6 offset", {24'd0, foundOffset}, {24'd0, expOff});
      chk("R9 blockCount", {26'd0, blockCount}, expCnt);
      chk("R6 R7 R8 errFlag", {31'd0, errFlag}, {31'd0, expErr});
      chk("R2 hdrType", {25'd0, hdrType}, {25'd0, cfgMem[3][22:16]});
      @(negedge clk);
      chk("R10 done one cycle", {30'd0, done, busy}, 32'd0);
    end
  endtask

  task automatic fillNoise();
    for (int i = 0; i < 64; i++) cfgMem[i] = $urandom;
  endtask

  // chain of 'n' blocks at distinct random dwords above the header
  task automatic buildRandom(input int n, input logic badPtr);
    logic used [64];
    int   idx [48];
    logic [7:0] ids [4] = '{8'h08, 8'h05, 8'h01, 8'h10};
    logic [7:0] tys [3] = '{8'h00, 8'h20, 8'h80};
    fillNoise();
    for (int i = 0; i < 64; i++) used[i] = 1'b0;
    for (int i = 0; i < n; i++) begin
      int k;
      do k = 16 + ($urandom % 48); while (used[k]);
      used[k] = 1'b1;
      idx[i] = k;
    end
    cfgMem[13][7:0] = {idx[0][5:0], 2'($urandom)};
    for (int i = 0; i < n; i++) begin
      logic [7:0] nxt;
      nxt = (i == n - 1) ? {6'd0, 2'($urandom)} : {idx[i+1][5:0], 2'($urandom)};
      if (badPtr && i == n - 1) nxt = 8'h04 + 8'($urandom % 60);
      cfgMem[idx[i]] = {tys[$urandom % 3], 8'($urandom), nxt, ids[$urandom % 4]};
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ok;
    logic [7:0] hOff;
    logic [5:0] hCnt;
    void'($urandom(32'h1F2E3D4C));
    fillNoise();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {26'd0, busy, done, found, errFlag, rdReq, 1'b0}, 32'd0);
    chk("R1 reset offset/count", {18'd0, foundOffset, blockCount}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // no capabilities, bridge header with bit 7 set (ignored)
    fillNoise();
    cfgMem[3]  = 32'h0081_0000;
    cfgMem[13] = 32'hABCD_EF00;
    runWalk(8'h08, 8'h00, 1'b0);
    chk("R6 empty list count", {26'd0, blockCount}, 32'd0);
    chk("R2 bridge format", {25'd0, hdrType}, 32'd1);

    // type skip chain: 0x40 (08,type 20) -> 0x80 (08,type 80) -> end
    fillNoise();
    cfgMem[3]  = 32'h0000_0000;
    cfgMem[13] = 32'h0000_0043;              // unaligned, R3
    cfgMem[16] = 32'h2000_8208;              // next 0x82 -> 0x80
    cfgMem[32] = 32'h8000_0008;
    runWalk(8'h08, 8'h80, 1'b1);
    chk("R5 type match offset", {24'd0, foundOffset}, 32'h80);
    chk("R9 type match count", {26'd0, blockCount}, 32'd2);
    chk("R3 read order cap ptr", {26'd0, addrLog[1]}, 32'd13);
    chk("R3 aligned first fetch", {26'd0, addrLog[2]}, 32'd16);
    chk("R6 aligned next fetch", {26'd0, addrLog[3]}, 32'd32);
    runWalk(8'h08, 8'h80, 1'b0);
    chk("R5 type ignored offset", {24'd0, foundOffset}, 32'h40);

    // R11: results hold while idle
    hOff = foundOffset; hCnt = blockCount;
    repeat (6) @(negedge clk);
    chk("R11 offset held", {24'd0, foundOffset}, {24'd0, hOff});
    chk("R11 count held", {26'd0, blockCount}, {26'd0, hCnt});

    // R10: second start while busy is ignored
    @(negedge clk);
    reqId = 8'h08; reqType = 8'h80; useType = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    reqId = 8'h05; useType = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(ok);
    chk("R10 ignored start offset", {24'd0, foundOffset}, 32'h80);
    chk("R10 ignored start found", {31'd0, found}, 32'd1);
    @(negedge clk);

    // R7: pointer back into header
    fillNoise();
    cfgMem[13] = 32'h0000_0040;
    cfgMem[16] = 32'h0000_1001;
    runWalk(8'h08, 8'h00, 1'b0);
    chk("R7 header pointer error", {31'd0, errFlag}, 32'd1);
    chk("R7 no read after error", logN, 32'd3);

    // R8: full 48-block chain, no match, ends cleanly
    fillNoise();
    cfgMem[13] = 32'h0000_0040;
    for (int i = 16; i < 64; i++)
      cfgMem[i] = {8'h00, 8'h00, (i == 63) ? 8'h00 : 8'((i + 1) * 4), 8'h01};
    runWalk(8'h08, 8'h00, 1'b0);
    chk("R8 exact limit no error", {31'd0, errFlag}, 32'd0);
    chk("R9 full chain count", {26'd0, blockCount}, 32'd48);
    cfgMem[63][7:0] = 8'h08;
    runWalk(8'h08, 8'h00, 1'b0);
    chk("R5 match at last block", {24'd0, foundOffset}, 32'hFC);

    // R8: circular list
    cfgMem[63][15:8] = 8'h40;
    cfgMem[63][7:0]  = 8'h01;
    runWalk(8'h08, 8'h00, 1'b0);
    chk("R8 circular error", {31'd0, errFlag}, 32'd1);
    chk("R8 circular count", {26'd0, blockCount}, 32'd48);

    // random chains
    for (int t = 0; t < 60; t++) begin
      logic [7:0] rid [4] = '{8'h08, 8'h05, 8'h01, 8'h10};
      logic [7:0] rty [3] = '{8'h00, 8'h20, 8'h80};
      buildRandom(1 + ($urandom % 12), ($urandom % 8) == 0);
      runWalk(rid[$urandom % 4], rty[$urandom % 3], 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule